// File: doc/BRIEF.md
# Write Auto-Precharge Bank Timer

This block follows a single DRAM bank through activation, writes and closing. It decodes a two-bit command stream. When a write arrives with the auto-precharge flag set, it works out the edge at which the bank's internal precharge begins and marks that edge with a one-cycle pulse. It then keeps the activate-ready level low until a new activate to the same bank is legal.

The start of precharge is the later of two points:
- the end of the write burst plus the write recovery delay;
- the minimum row-active time after the activate.

Reactivation waits for both of these:
- the row-precharge time after precharge began;
- the row-cycle time after the previous activate.

An activate issued too early, or a write to a bank that cannot accept one, sets a sticky error flag. The timing values come from configuration inputs. They are captured only while the bank is idle.

Edges are numbered by the rising clock edge that samples a command. In what follows, `a` is the edge of the last accepted activate and `w` is the edge of the auto-precharge write. "Due before edge k" means the output is valid in the clock cycle that ends at edge k.

Top module: `wapt_bank_timer`

## Requirements
- R1: After reset the bank is idle and precharged: `act_ready`=1, `bank_open`=0, `pre_start`=0, `err_flag`=0.
- R2: Command codes are 00 no-op, 01 activate, 10 write and 11 precharge. An activate sampled while `act_ready`=1 opens the bank: from the next cycle `bank_open`=1 and `act_ready`=0.
- R3: A write with `ap_flag`=0 leaves the bank open and produces no `pre_start` pulse. A precharge command (11) on an open bank closes it with no `pre_start` pulse.
- R4: After a write with `ap_flag`=1, `pre_start` is high for exactly one cycle. That cycle is due before edge p = max(w + WL + B + WRc, a + tRAS). B is 2 when `cfg_bl8`=0 (burst of four) and 4 when `cfg_bl8`=1 (burst of eight).
- R5: WRc is `cfg_wr` limited to the range 2 to 6: values 0 and 1 act as 2, and 7 acts as 6.
- R6: After an auto-precharge, `act_ready` rises in the cycle due before edge max(p + tRP, a + tRC).
- R7: After a precharge command sampled at edge q, `act_ready` rises in the cycle due before edge max(q + tRP, a + tRC).
- R8: An activate sampled while `act_ready`=0 sets `err_flag`, which stays set until reset. The activate is otherwise ignored: all timing still counts from the earlier activate.
- R9: A write sampled while the bank is idle, closing, or waiting for its auto-precharge sets `err_flag`.
- R10: The configuration inputs are captured only while the bank is idle. Changing them at any other time has no effect on the timing of the bank's current open-and-close cycle.
- R11: A precharge command sampled while an auto-precharge is pending is ignored: the timing is unchanged and `err_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command: 00 no-op, 01 activate, 10 write, 11 precharge |
| ap_flag | input | 1 | Auto-precharge request, used with a write |
| cfg_wl | input | CW | Write latency in cycles |
| cfg_bl8 | input | 1 | 1: burst of eight, 0: burst of four |
| cfg_wr | input | 3 | Write recovery in cycles (limited to 2..6) |
| cfg_trp | input | CW | Row-precharge time in cycles |
| cfg_tras | input | CW | Minimum row-active time in cycles |
| cfg_trc | input | CW | Row-cycle time in cycles |
| pre_start | output | 1 | One-cycle pulse when the internal precharge begins |
| act_ready | output | 1 | High while an activate would be legal |
| bank_open | output | 1 | High while the bank is open or waiting for its auto-precharge |
| err_flag | output | 1 | Sticky timing or protocol error |

## Verification
All outputs are decoded from registered state, so each result is due in the cycle that ends at the edge the formulas give. `bank_open`, `act_ready` and `err_flag` change one edge after the command that causes the change. The bench drives commands on falling edges and records the next rising-edge index as the edge of each command. It samples outputs on falling edges and turns the first cycle with a `pre_start` or `act_ready` observation into an edge number. These edge numbers are compared with p and the ready edge, which the bench computes arithmetically from the swept configuration. The sweep covers the write latency, the burst length, every write recovery code, two values each of tRP, tRAS and tRC, and two activate-to-write gaps. This makes either the tRAS limit or the recovery limit, and either the tRP limit or the tRC limit, the deciding one.

// File: rtl/wapt_pkg.sv
package wapt_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_APWAIT,
        ST_CLOSING
    } bank_st_e;

    localparam int unsigned WR_MIN = 2;
    localparam int unsigned WR_MAX = 6;

endpackage

// File: rtl/wapt_tick_ctr.sv
// Saturating distance counter: reads 1 after the edge that restarts it and
// grows by one per edge, so before edge k it holds k minus the restart edge.
module wapt_tick_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = W'(1);
        else if (cnt_q != '1)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wapt_cfg_hold.sv
// Captures timing settings while the bank is idle (R10) and limits the
// write recovery code to its legal range (R5).
module wapt_cfg_hold #(
    parameter int CW = 6,
    parameter int TW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] wl,
    input  logic          bl8,
    input  logic [2:0]    wr,
    input  logic [CW-1:0] trp,
    input  logic [CW-1:0] tras,
    input  logic [CW-1:0] trc,
    output logic [TW-1:0] thr_pre,
    output logic [TW-1:0] thr_trp,
    output logic [TW-1:0] thr_tras,
    output logic [TW-1:0] thr_trc
);
    import wapt_pkg::*;

    typedef struct packed {
        logic [CW-1:0] wl;
        logic          bl8;
        logic [2:0]    wr;
        logic [CW-1:0] trp;
        logic [CW-1:0] tras;
        logic [CW-1:0] trc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [2:0] wr_lim;

    always_comb begin
        if (wr < 3'(WR_MIN))      wr_lim = 3'(WR_MIN);
        else if (wr > 3'(WR_MAX)) wr_lim = 3'(WR_MAX);
        else                      wr_lim = wr;
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.wl   = wl;
            cfg_d.bl8  = bl8;
            cfg_d.wr   = wr_lim;
            cfg_d.trp  = trp;
            cfg_d.tras = tras;
            cfg_d.trc  = trc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign thr_pre  = TW'(cfg_q.wl) + (cfg_q.bl8 ? TW'(4) : TW'(2)) + TW'(cfg_q.wr);
    assign thr_trp  = TW'(cfg_q.trp);
    assign thr_tras = TW'(cfg_q.tras);
    assign thr_trc  = TW'(cfg_q.trc);
endmodule

// File: rtl/wapt_bank_timer.sv
module wapt_bank_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd,
    input  logic          ap_flag,
    input  logic [CW-1:0] cfg_wl,
    input  logic          cfg_bl8,
    input  logic [2:0]    cfg_wr,
    input  logic [CW-1:0] cfg_trp,
    input  logic [CW-1:0] cfg_tras,
    input  logic [CW-1:0] cfg_trc,
    output logic          pre_start,
    output logic          act_ready,
    output logic          bank_open,
    output logic          err_flag
);
    import wapt_pkg::*;

    localparam int TW    = CW + 2;  // wide enough for WL + burst + WR
    localparam int NCTR  = 3;
    localparam int C_AGE = 0;       // since last accepted activate
    localparam int C_WR  = 1;       // since auto-precharge write
    localparam int C_PRE = 2;       // since precharge began

    typedef struct packed {
        bank_st_e st;
        logic     err;
    } state_t;

    state_t s_d, s_q;
    cmd_e   c;
    logic [NCTR-1:0] restart;
    logic [TW-1:0]   cnt [NCTR];
    logic [TW-1:0]   thr_pre, thr_trp, thr_tras, thr_trc;
    logic            pre_due, reuse_ok;

    assign c = cmd_e'(cmd);

    wapt_cfg_hold #(.CW(CW), .TW(TW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(s_q.st == ST_IDLE),
        .wl(cfg_wl), .bl8(cfg_bl8), .wr(cfg_wr),
        .trp(cfg_trp), .tras(cfg_tras), .trc(cfg_trc),
        .thr_pre(thr_pre), .thr_trp(thr_trp),
        .thr_tras(thr_tras), .thr_trc(thr_trc)
    );

    for (genvar gi = 0; gi < NCTR; gi++) begin : g_ctr
        wapt_tick_ctr #(.W(TW)) u_ctr (
            .clk(clk), .rst_n(rst_n), .restart(restart[gi]), .cnt(cnt[gi])
        );
    end

    // R4: burst plus recovery done and row active long enough
    assign pre_due  = (cnt[C_WR] >= thr_pre) && (cnt[C_AGE] >= thr_tras);
    // R6/R7: precharge time and row-cycle time both met
    assign reuse_ok = (cnt[C_PRE] >= thr_trp) && (cnt[C_AGE] >= thr_trc);

    always_comb begin
        s_d     = s_q;
        restart = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (c == CMD_ACT) begin
                    s_d.st         = ST_OPEN;
                    restart[C_AGE] = 1'b1;
                end else if (c == CMD_WR) begin
                    s_d.err = 1'b1;                  // R9
                end
            end
            ST_OPEN: begin
                if (c == CMD_ACT) begin
                    s_d.err = 1'b1;                  // R8
                end else if (c == CMD_WR && ap_flag) begin
                    s_d.st        = ST_APWAIT;
                    restart[C_WR] = 1'b1;
                end else if (c == CMD_PRE) begin
                    s_d.st         = ST_CLOSING;     // R7
                    restart[C_PRE] = 1'b1;
                end
            end
            ST_APWAIT: begin
                if (c == CMD_ACT || c == CMD_WR)
                    s_d.err = 1'b1;                  // R8, R9; PRE ignored (R11)
                if (pre_due) begin
                    s_d.st         = ST_CLOSING;
                    restart[C_PRE] = 1'b1;
                end
            end
            ST_CLOSING: begin
                if (c == CMD_ACT) begin
                    if (reuse_ok) begin
                        s_d.st         = ST_OPEN;
                        restart[C_AGE] = 1'b1;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end else begin
                    if (c == CMD_WR) s_d.err = 1'b1;
                    if (reuse_ok)    s_d.st  = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;                      // R1
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pre_start = (s_q.st == ST_APWAIT) && pre_due;
    assign act_ready = (s_q.st == ST_IDLE) || ((s_q.st == ST_CLOSING) && reuse_ok);
    assign bank_open = (s_q.st == ST_OPEN) || (s_q.st == ST_APWAIT);
    assign err_flag  = s_q.err;
endmodule

// File: rtl/wapt_bank_timer_chk.sv
module wapt_bank_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       ap_flag,
    input logic       pre_start,
    input logic       act_ready,
    input logic       bank_open,
    input logic       err_flag
);
    AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start |=> !pre_start);                                   // R4
    AST_PRE_ENDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start |-> (bank_open && !act_ready));                    // R4
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start |=> !bank_open);                                   // R6
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && act_ready) |=> (bank_open && !act_ready));  // R2
    AST_EARLY_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !act_ready) |=> err_flag);                  // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);                                      // R8
    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !bank_open) |=> err_flag);                  // R9
    AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !ap_flag && bank_open && !pre_start && !err_flag)
        |=> (!pre_start || $past(ap_flag)));                         // R3
endmodule

bind wapt_bank_timer wapt_bank_timer_chk u_chk (.*);

// File: tb/tb_wapt_bank_timer.sv
`timescale 1ns/1ps
module tb_wapt_bank_timer;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    cmd;
    logic          ap_flag;
    logic [CW-1:0] cfg_wl, cfg_trp, cfg_tras, cfg_trc;
    logic          cfg_bl8;
    logic [2:0]    cfg_wr;
    logic          pre_start, act_ready, bank_open, err_flag;

    wapt_bank_timer #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ap_flag(ap_flag),
        .cfg_wl(cfg_wl), .cfg_bl8(cfg_bl8), .cfg_wr(cfg_wr),
        .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_trc(cfg_trc),
        .pre_start(pre_start), .act_ready(act_ready),
        .bank_open(bank_open), .err_flag(err_flag)
    );

    int ec = 0;
    always @(posedge clk) ec <= ec + 1;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;
    logic s_ready, s_open;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int wr_lim(input int v);
        if (v < 2) return 2;
        if (v > 6) return 6;
        return v;
    endfunction

    task automatic set_cfg(input int wl, input int bl8, input int wr,
                           input int trp, input int tras, input int trc);
        cfg_wl = CW'(wl); cfg_bl8 = bl8[0]; cfg_wr = 3'(wr);
        cfg_trp = CW'(trp); cfg_tras = CW'(tras); cfg_trc = CW'(trc);
    endtask

    task automatic issue(input logic [1:0] c, input logic ap, output int e);
        @(negedge clk);
        s_ready = act_ready;
        s_open  = bank_open;
        cmd = c; ap_flag = ap;
        e = ec + 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd = 2'b00; ap_flag = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd = 2'b00; ap_flag = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Records the edge of the first pre_start cycle and of the first act_ready cycle.
    task automatic wait_ready(output int p, output int r);
        p = -1; r = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pre_start && p < 0) p = ec + 1;
            cmd = 2'b00; ap_flag = 1'b0;
            if (act_ready) begin
                r = ec + 1;
                break;
            end
        end
        if (r < 0) chk(1'b0, "watchdog wait_ready", r, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog global", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int a, w, q, p, r, e2, ep, er, bursts, cnt_bad;
        rst_n = 1'b0; cmd = 2'b00; ap_flag = 1'b0;
        set_cfg(2, 0, 3, 3, 4, 12);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(act_ready == 1'b1, "R1 act_ready", act_ready, 1);
        chk(bank_open == 1'b0, "R1 bank_open", bank_open, 0);
        chk(pre_start == 1'b0, "R1 pre_start", pre_start, 0);
        chk(err_flag  == 1'b0, "R1 err_flag", err_flag, 0);

        // Sweep: R2, R4, R5, R6
        for (int wl = 1; wl <= 3; wl++)
        for (int bl = 0; bl <= 1; bl++)
        for (int wr = 0; wr <= 7; wr++)
        for (int tp = 2; tp <= 3; tp++)
        for (int ti = 0; ti <= 1; ti++)
        for (int ci = 0; ci <= 1; ci++)
        for (int gp = 1; gp <= 4; gp += 3) begin
            int tras, trc;
            tras = ti ? 10 : 3;
            trc  = ci ? 15 : 5;
            set_cfg(wl, bl, wr, tp, tras, trc);
            issue(2'b01, 1'b0, a);
            idle(gp - 1);
            issue(2'b10, 1'b1, w);
            chk(s_ready == 1'b0 && s_open == 1'b1, "R2 open after activate",
                {s_ready, s_open}, 1);
            wait_ready(p, r);
            ep = imax(w + wl + (bl ? 4 : 2) + wr_lim(wr), a + tras);
            er = imax(ep + tp, a + trc);
            chk(p == ep, (wr < 2 || wr > 6) ? "R5 clamped pre edge" : "R4 pre edge", p, ep);
            chk(r == er, "R6 ready edge", r, er);
            chk(err_flag == 1'b0, "R8 no error on legal sequence", err_flag, 0);
            idle(1);
        end

        // R3 plain write then R7 precharge command
        do_reset();
        set_cfg(2, 1, 4, 3, 4, 20);
        issue(2'b01, 1'b0, a);
        issue(2'b10, 1'b0, w);
        cnt_bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cmd = 2'b00;
            if (pre_start || !bank_open) cnt_bad++;
        end
        chk(cnt_bad == 0, "R3 plain write keeps bank open", cnt_bad, 0);
        issue(2'b11, 1'b0, q);
        wait_ready(p, r);
        chk(p == -1, "R3 no pulse on precharge command", p, -1);
        er = imax(q + 3, a + 20);
        chk(r == er, "R7 ready after precharge cmd", r, er);
        idle(1);
        issue(2'b01, 1'b0, a);
        issue(2'b11, 1'b0, q);
        wait_ready(p, r);
        er = imax(q + 3, a + 20);
        chk(r == er, "R7 row cycle limit", r, er);

        // R8 early activate: flagged, ignored
        do_reset();
        set_cfg(2, 0, 3, 3, 4, 12);
        issue(2'b01, 1'b0, a);
        issue(2'b01, 1'b0, e2);
        issue(2'b10, 1'b1, w);
        chk(err_flag == 1'b1, "R8 early activate flagged", err_flag, 1);
        wait_ready(p, r);
        ep = imax(w + 2 + 2 + 3, a + 4);
        er = imax(ep + 3, a + 12);
        chk(p == ep, "R8 timing from first activate (pre)", p, ep);
        chk(r == er, "R8 timing from first activate (ready)", r, er);
        idle(5);
        chk(err_flag == 1'b1, "R8 flag sticky", err_flag, 1);

        // R9 write to idle bank
        do_reset();
        issue(2'b10, 1'b1, w);
        idle(1);
        chk(err_flag == 1'b1, "R9 write to idle", err_flag, 1);
        chk(bank_open == 1'b0, "R9 idle bank stays closed", bank_open, 0);

        // R9 write while auto-precharge pending
        do_reset();
        issue(2'b01, 1'b0, a);
        issue(2'b10, 1'b1, w);
        issue(2'b10, 1'b0, e2);
        idle(1);
        chk(err_flag == 1'b1, "R9 write during pending precharge", err_flag, 1);
        wait_ready(p, r);

        // R10 config change while busy
        do_reset();
        set_cfg(1, 0, 2, 2, 3, 5);
        issue(2'b01, 1'b0, a);
        issue(2'b10, 1'b1, w);
        set_cfg(3, 1, 6, 7, 30, 40);
        wait_ready(p, r);
        ep = imax(w + 1 + 2 + 2, a + 3);
        er = imax(ep + 2, a + 5);
        chk(p == ep, "R10 pre edge uses captured config", p, ep);
        chk(r == er, "R10 ready edge uses captured config", r, er);

        // R11 precharge during pending auto-precharge
        do_reset();
        set_cfg(2, 1, 5, 3, 6, 14);
        issue(2'b01, 1'b0, a);
        issue(2'b10, 1'b1, w);
        issue(2'b11, 1'b0, e2);
        wait_ready(p, r);
        ep = imax(w + 2 + 4 + 5, a + 6);
        er = imax(ep + 3, a + 14);
        chk(p == ep, "R11 pre edge unchanged", p, ep);
        chk(r == er, "R11 ready edge unchanged", r, er);
        chk(err_flag == 1'b0, "R11 no error", err_flag, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule